// File: doc/BRIEF.md
# Bus Address Region Decoder

This block sits between a CPU bus and the memories and peripheral fabric behind it. It takes a 32-bit byte address and a read or write strobe. In the same cycle it reports which physical region the access targets: main RAM, boot ROM, the I/O register window, the bus-interface control register page, or nothing at all. It also gives the offset of the access inside that region.

The upper 16 address bits name a 64 KiB page. The top three of those bits are a segment number. Three segments (0, 4 and 5) are folded onto one physical map, so the cached and uncached views of RAM and ROM land in the same place. The decode is purely combinational and has no handshake. The bus master holds the address and strobes stable for as long as it needs the result, and the block never applies back-pressure.

One piece of state lives here: a RAM write-lock flag. A full-word write of a set value to the control register turns the lock on, and a clear value turns it off. While the lock is on, every RAM write is flagged as suppressed. A downstream multiplexer uses `rd_zero` to return zero for reads that hit nothing.

Top module: `addr_region_dec`

## Requirements
- R1: `region_sel` is one-hot in every cycle and is valid in the same cycle as `addr`. Bit 0 means unmapped, bit 1 RAM, bit 2 ROM, bit 3 I/O and bit 4 control page. Unmapped is the default, and `region_off` is zero for unmapped and control-page accesses.
- R2: Pages 0x0000–0x007F select RAM, and so do the same pages ORed with 0x8000 or 0xA000. For these, `region_off` = {page[6:0], addr[15:0]}. Pages in segments 1, 2, 3, 6 and 7 never select RAM.
- R3: Pages 0x1FC0–0x1FC7 select ROM, and so do the same pages ORed with 0x8000 or 0xA000. For these, `region_off` = (page − 0x1FC0) concatenated with addr[15:0]. Any write to ROM raises `wr_block`.
- R4: Page 0x1F80 selects I/O only when addr[15:0] lies in 0x1000–0x187F, and then `region_off` = addr[15:0]. Other offsets in that page, and page 0x9F80, are unmapped. I/O writes never raise `wr_block`.
- R5: Page 0xFFFE selects the control page. Reads there raise `rd_zero`, and writes there raise `wr_block`.
- R6: A write with all four byte enables set to address 0xFFFE0130, carrying data 0x800 or 0x804, sets the lock from the next cycle on.
- R7: The same kind of write carrying 0x0 or 0x1E988 clears the lock. Other data values, other addresses in page 0xFFFE and writes with partial byte enables leave the lock unchanged.
- R8: While the lock is set, a RAM write in any of the three segments raises `wr_block`. RAM reads and I/O writes are not affected.
- R9: A read from an unmapped address raises `rd_zero`, and a write to an unmapped address raises `wr_block`.
- R10: Reset (`rst_n` low) clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the lock flag |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Byte address of the access |
| be | input | 4 | Byte enables |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| region_sel | output | 5 | One-hot region select |
| region_off | output | 23 | Offset inside the selected region |
| wr_block | output | 1 | Write must not reach any target |
| rd_zero | output | 1 | Read data must be forced to zero |

## Verification
The bench probes the edges of every region: the last RAM page and the page after it, both ends of the ROM pages, and the first and last I/O offsets with the offsets just outside them. A decoder with an off-by-one limit would report the wrong region at one of these points. It also checks segments that must not fold (0xC000 and 0x9F80); a decoder that masks too many segment bits would map them onto RAM or I/O. Writes to the lock register use non-magic data, a neighbouring offset and partial byte enables, and a decoder that matches too loosely would change the lock on one of them. RAM writes are then probed in all three segments, so a lock that misses a mirror is caught.

// File: rtl/addr_region_pkg.sv
package addr_region_pkg;
  localparam int REGION_N = 5;
  localparam int RG_NONE  = 0;
  localparam int RG_RAM   = 1;
  localparam int RG_ROM   = 2;
  localparam int RG_IO    = 3;
  localparam int RG_CTL   = 4;
  typedef logic [REGION_N-1:0] region_vec_t;
endpackage

// File: rtl/region_classify.sv
module region_classify import addr_region_pkg::*; #(
  parameter logic [7:0]  MIRROR_SEGS = 8'b0011_0001,
  parameter int          RAM_PAGES   = 128,
  parameter logic [12:0] ROM_BASE    = 13'h1FC0,
  parameter int          ROM_PAGES   = 8,
  parameter logic [15:0] IO_PAGE     = 16'h1F80,
  parameter logic [15:0] IO_LO       = 16'h1000,
  parameter logic [15:0] IO_HI       = 16'h187F,
  parameter logic [15:0] CTL_PAGE    = 16'hFFFE
) (
  input  logic [31:0] addr,
  output region_vec_t sel
);
  localparam logic [12:0] RAM_LIM = 13'(RAM_PAGES);
  localparam logic [12:0] ROM_END = ROM_BASE + 13'(ROM_PAGES);

  logic [2:0]  seg;
  logic [12:0] low;
  logic [15:0] pg_off;
  logic fold_ok, ram_hit, rom_hit, io_hit, ctl_hit;

  assign seg     = addr[31:29];
  assign low     = addr[28:16];
  assign pg_off  = addr[15:0];
  assign fold_ok = MIRROR_SEGS[seg];

  assign ram_hit = fold_ok && (low < RAM_LIM);
  assign rom_hit = fold_ok && (low >= ROM_BASE) && (low < ROM_END);
  assign io_hit  = (addr[31:16] == IO_PAGE) && (pg_off >= IO_LO) && (pg_off <= IO_HI);
  assign ctl_hit = (addr[31:16] == CTL_PAGE);

  always_comb begin
    sel = '0;
    if (ram_hit)      sel[RG_RAM]  = 1'b1;
    else if (rom_hit) sel[RG_ROM]  = 1'b1;
    else if (io_hit)  sel[RG_IO]   = 1'b1;
    else if (ctl_hit) sel[RG_CTL]  = 1'b1;
    else              sel[RG_NONE] = 1'b1;
  end
endmodule

// File: rtl/region_offset.sv
module region_offset import addr_region_pkg::*; #(
  parameter int          RAM_PAGES = 128,
  parameter int          ROM_PAGES = 8,
  parameter logic [12:0] ROM_BASE  = 13'h1FC0,
  parameter int          OFF_W     = 23
) (
  input  logic [12:0]     low,
  input  logic [15:0]     pg_off,
  input  region_vec_t     sel,
  output logic [OFF_W-1:0] off
);
  localparam int RAM_W = 16 + $clog2(RAM_PAGES);
  localparam int ROM_W = 16 + $clog2(ROM_PAGES);
  localparam logic [28:0] RAM_MASK = 29'((64'd1 << RAM_W) - 64'd1);
  localparam logic [28:0] ROM_MASK = 29'((64'd1 << ROM_W) - 64'd1);

  logic [12:0] rom_idx;
  logic [28:0] ram_full, rom_full, io_full;

  assign rom_idx  = low - ROM_BASE;
  assign ram_full = {low, pg_off} & RAM_MASK;
  assign rom_full = {rom_idx, pg_off} & ROM_MASK;
  assign io_full  = {13'd0, pg_off};

  always_comb begin
    off = '0;
    if (sel[RG_NONE] || sel[RG_CTL]) off = '0;
    else if (sel[RG_RAM])            off = OFF_W'(ram_full);
    else if (sel[RG_ROM])            off = OFF_W'(rom_full);
    else if (sel[RG_IO])             off = OFF_W'(io_full);
  end
endmodule

// File: rtl/biu_lock.sv
module biu_lock #(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] REG_ADDR = 32'hFFFE_0130,
  parameter logic [31:0] SET_A    = 32'h0000_0800,
  parameter logic [31:0] SET_B    = 32'h0000_0804,
  parameter logic [31:0] CLR_A    = 32'h0000_0000,
  parameter logic [31:0] CLR_B    = 32'h0001_E988,
  localparam int         BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked
);
  logic hit, do_set, do_clr;

  assign hit    = wr_en && (addr == REG_ADDR) && (&be);
  assign do_set = hit && ((wr_data == DATA_W'(SET_A)) || (wr_data == DATA_W'(SET_B)));
  assign do_clr = hit && ((wr_data == DATA_W'(CLR_A)) || (wr_data == DATA_W'(CLR_B)));

  always_ff @(posedge clk) begin
    if (!rst_n)      locked <= 1'b0;
    else if (do_set) locked <= 1'b1;
    else if (do_clr) locked <= 1'b0;
  end
endmodule

// File: rtl/addr_region_dec.sv
module addr_region_dec import addr_region_pkg::*; #(
  parameter int          RAM_PAGES   = 128,
  parameter int          ROM_PAGES   = 8,
  parameter logic [12:0] ROM_BASE    = 13'h1FC0,
  parameter logic [7:0]  MIRROR_SEGS = 8'b0011_0001,
  parameter logic [15:0] IO_PAGE     = 16'h1F80,
  parameter logic [15:0] IO_LO       = 16'h1000,
  parameter logic [15:0] IO_HI       = 16'h187F,
  parameter logic [15:0] CTL_PAGE    = 16'hFFFE,
  parameter logic [15:0] CTL_OFF     = 16'h0130,
  parameter int          DATA_W      = 32,
  localparam int         BE_W        = DATA_W / 8,
  localparam int         OFF_W       = 16 + $clog2(RAM_PAGES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         addr,
  input  logic [BE_W-1:0]     be,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [REGION_N-1:0] region_sel,
  output logic [OFF_W-1:0]    region_off,
  output logic                wr_block,
  output logic                rd_zero
);
  region_vec_t sel;
  logic        lock_q;

  region_classify #(
    .MIRROR_SEGS(MIRROR_SEGS), .RAM_PAGES(RAM_PAGES), .ROM_BASE(ROM_BASE),
    .ROM_PAGES(ROM_PAGES), .IO_PAGE(IO_PAGE), .IO_LO(IO_LO), .IO_HI(IO_HI),
    .CTL_PAGE(CTL_PAGE)
  ) u_classify (
    .addr(addr),
    .sel (sel)
  );

  region_offset #(
    .RAM_PAGES(RAM_PAGES), .ROM_PAGES(ROM_PAGES), .ROM_BASE(ROM_BASE), .OFF_W(OFF_W)
  ) u_offset (
    .low   (addr[28:16]),
    .pg_off(addr[15:0]),
    .sel   (sel),
    .off   (region_off)
  );

  biu_lock #(
    .DATA_W(DATA_W), .REG_ADDR({CTL_PAGE, CTL_OFF})
  ) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .be     (be),
    .wr_data(wr_data),
    .locked (lock_q)
  );

  assign region_sel = sel;
  // a write reaches a target only for I/O, or for RAM while unlocked
  assign wr_block = wr_en && !(sel[RG_IO] || (sel[RG_RAM] && !lock_q));
  assign rd_zero  = rd_en && (sel[RG_NONE] || sel[RG_CTL]);
endmodule

// File: rtl/addr_region_dec_chk.sv
module addr_region_dec_chk import addr_region_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic [31:0]         addr,
  input logic [3:0]          be,
  input logic                rd_en,
  input logic                wr_en,
  input logic [31:0]         wr_data,
  input logic [REGION_N-1:0] region_sel,
  input logic                wr_block,
  input logic                rd_zero,
  input logic                lock_q
);
  logic reg_wr, magic_set, magic_clr;
  assign reg_wr    = wr_en && (addr == 32'hFFFE_0130) && (be == 4'hF);
  assign magic_set = reg_wr && ((wr_data == 32'h800) || (wr_data == 32'h804));
  assign magic_clr = reg_wr && ((wr_data == 32'h0) || (wr_data == 32'h1E988));

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(region_sel));
  p_rom_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region_sel[RG_ROM]) |-> wr_block);
  p_io_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region_sel[RG_IO]) |-> !wr_block);
  p_ctl_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region_sel[RG_CTL]) |-> rd_zero);
  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    magic_set |=> lock_q);
  p_lock_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    magic_clr |=> !lock_q);
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(magic_set || magic_clr) |=> $stable(lock_q));
  p_ram_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && region_sel[RG_RAM]) |-> wr_block);
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && region_sel[RG_NONE]) |-> rd_zero);
endmodule

bind addr_region_dec addr_region_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .region_sel(region_sel), .wr_block(wr_block),
  .rd_zero(rd_zero), .lock_q(lock_q)
);

// File: tb/addr_region_dec_test.sv
module addr_region_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  region_sel;
  logic [22:0] region_off;
  logic        wr_block, rd_zero;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_region_dec uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .be(be), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .region_sel(region_sel), .region_off(region_off),
    .wr_block(wr_block), .rd_zero(rd_zero)
  );

  localparam logic [4:0] S_NONE = 5'b00001, S_RAM = 5'b00010, S_ROM = 5'b00100,
                         S_IO = 5'b01000, S_CTL = 5'b10000;

  function automatic logic [63:0] mk(input logic [31:0] a, input logic r, input logic w,
                                     input logic [4:0] s, input logic [22:0] o,
                                     input logic wb, input logic rz);
    return {a, r, w, s, o, wb, rz};
  endfunction

  localparam int NV = 17;
  localparam logic [63:0] VEC [NV] = '{
    mk(32'h0000_1234, 1, 0, S_RAM,  23'h001234, 0, 0),
    mk(32'h807F_FFFC, 0, 1, S_RAM,  23'h7FFFFC, 0, 0),
    mk(32'hA010_0008, 1, 0, S_RAM,  23'h100008, 0, 0),
    mk(32'h0080_0000, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'hBFC0_0100, 1, 0, S_ROM,  23'h000100, 0, 0),
    mk(32'h9FC7_FFFF, 1, 0, S_ROM,  23'h07FFFF, 0, 0),
    mk(32'h1FC0_0000, 0, 1, S_ROM,  23'h000000, 1, 0),
    mk(32'h1FC8_0000, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'h1F80_1000, 0, 1, S_IO,   23'h001000, 0, 0),
    mk(32'h1F80_187F, 1, 0, S_IO,   23'h00187F, 0, 0),
    mk(32'h1F80_1880, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'h1F80_0FFF, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'h9F80_1000, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'hFFFE_0130, 1, 0, S_CTL,  23'h0,      0, 1),
    mk(32'h4000_0000, 0, 1, S_NONE, 23'h0,      1, 0),
    mk(32'hC000_0000, 1, 0, S_NONE, 23'h0,      0, 1),
    mk(32'hFFFE_0000, 0, 1, S_CTL,  23'h0,      1, 0)
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2, 15: return "R2";
      3, 7, 14:    return "R9";
      4, 5, 6:     return "R3";
      8, 9, 10, 11, 12: return "R4";
      default:     return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic ctl_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = a; wr_data = d; be = b; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; be = 4'hF;
  endtask

  task automatic probe(input logic [31:0] a, input logic r, input logic w,
                       input logic exp_wb, input string tag);
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wr_data = 32'h5A5A_5A5A;
    #1;
    chk(wr_block == exp_wb, tag, {31'd0, wr_block}, {31'd0, exp_wb});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: lock clear after reset, RAM write passes
    probe(32'h0000_0010, 0, 1, 1'b0, "R10 reset lock clear");

    // R1 R2 R3 R4 R5 R9: table walk with lock clear
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i][63:32]; rd_en = VEC[i][31]; wr_en = VEC[i][30]; wr_data = '0; be = 4'hF;
      #1;
      chk(region_sel == VEC[i][29:25], $sformatf("R1/%s sel vec %0d", vtag(i), i),
          {27'd0, region_sel}, {27'd0, VEC[i][29:25]});
      chk(region_off == VEC[i][24:2], $sformatf("%s off vec %0d", vtag(i), i),
          {9'd0, region_off}, {9'd0, VEC[i][24:2]});
      chk(wr_block == VEC[i][1], $sformatf("%s wr_block vec %0d", vtag(i), i),
          {31'd0, wr_block}, {31'd0, VEC[i][1]});
      chk(rd_zero == VEC[i][0], $sformatf("%s rd_zero vec %0d", vtag(i), i),
          {31'd0, rd_zero}, {31'd0, VEC[i][0]});
    end
    rd_en = 1'b0; wr_en = 1'b0;

    // R6 R8: set lock with 0x800, check all mirrors
    ctl_wr(32'hFFFE_0130, 32'h800, 4'hF);
    probe(32'h0000_0000, 0, 1, 1'b1, "R6 lock via 0x800");
    probe(32'h8001_0000, 0, 1, 1'b1, "R8 seg4 mirror blocked");
    probe(32'hA07F_0000, 0, 1, 1'b1, "R8 seg5 mirror blocked");
    probe(32'h0000_0004, 1, 0, 1'b0, "R8 ram read unaffected");
    chk(rd_zero == 1'b0, "R8 ram read not zeroed", {31'd0, rd_zero}, 32'd0);
    probe(32'h1F80_1010, 0, 1, 1'b0, "R8 io write passes");

    // R7: non-clearing writes keep lock
    ctl_wr(32'hFFFE_0130, 32'h1234_5678, 4'hF);
    probe(32'h0000_0100, 0, 1, 1'b1, "R7 other value ignored");
    ctl_wr(32'hFFFE_0134, 32'h0, 4'hF);
    probe(32'h0000_0100, 0, 1, 1'b1, "R7 other offset ignored");
    ctl_wr(32'hFFFE_0130, 32'h0, 4'h3);
    probe(32'h0000_0100, 0, 1, 1'b1, "R7 partial byte enable ignored");
    ctl_wr(32'hFFFE_0130, 32'h1E988, 4'hF);
    probe(32'h0000_0100, 0, 1, 1'b0, "R7 clear via 0x1E988");

    // R6 second set value, R7 clear via zero
    ctl_wr(32'hFFFE_0130, 32'h804, 4'hF);
    probe(32'h8000_0200, 0, 1, 1'b1, "R6 lock via 0x804");
    ctl_wr(32'hFFFE_0130, 32'h0, 4'hF);
    probe(32'h8000_0200, 0, 1, 1'b0, "R7 clear via 0x0");

    // R10: reset while locked
    ctl_wr(32'hFFFE_0130, 32'h800, 4'hF);
    probe(32'hA000_0000, 0, 1, 1'b1, "R6 relock before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    probe(32'hA000_0000, 0, 1, 1'b0, "R10 reset clears lock");

    done = 1'b1;
    report();
    $finish;
  end
endmodule